// File: doc/BRIEF.md
# SPI Burst Transfer Engine

This block sits between a transmit word queue, a receive word queue and a byte-wide SPI shifter. When it is started, it takes 32-bit words from the transmit queue one at a time. It hands each word to the shifter as a series of bytes, least significant byte first, and packs the bytes returned by the shifter into a word that it pushes to the receive queue. A programmed burst length in bits decides how many bytes each word contributes. A burst may cover several words, and it may also end partway through a word.

Two kinds of event start a drain. The first is a word being written to the transmit queue while the start-on-write control is set and the block is master. The second is an exchange request while that control is clear and the block is master. A per-channel waveform bit, taken for the selected channel, decides what happens at the end of a burst. In continuous mode, which also needs the start-on-write control clear, draining carries on into a fresh burst. In every other case the engine raises transfer-complete and pauses, even when the queue still holds words. Because the remaining bit count is kept across pauses, a later start continues the burst that was interrupted.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset the transfer-complete, overflow and exchange-busy outputs are low, and no queue pop, queue push or byte request is made.
- R2: The burst length is the burst field value plus one, in bits. A new burst length is loaded only when the remaining count is zero or negative. The remaining count is kept across pauses and restarts.
- R3: For each popped word the engine shifts ceil(min(remaining, 32)/8) bytes, least significant byte first. The remaining count drops by 8 for each byte.
- R4: A byte request stays high with a stable byte value until the shifter answers with byte-done. Each byte-done accepts exactly one byte.
- R5: The byte returned for byte index k lands at bits 8k+7..8k of the receive word. Lanes that were not shifted read as zero. One push is made per word.
- R6: When the receive queue is full as a word completes, the word is dropped and the overflow flag is set. A full queue is never pushed.
- R7: Outside continuous mode, the end of a burst sets transfer-complete and stops the drain, and any remaining transmit words are left in place.
- R8: Continuous mode applies when the block is master, start-on-write is clear and the waveform bit of the selected channel is set. In this mode bursts follow one another until the queue is empty, and exchange-busy is high whenever a word is popped.
- R9: When the engine finds the transmit queue empty, it sets transfer-complete and drops exchange-busy. A paused drain leaves exchange-busy unchanged.
- R10: A drain starts only on a queue write with start-on-write set, or on an exchange request with start-on-write clear, and in both cases only as master. An exchange request sets exchange-busy. All other start events are ignored.
- R11: The done-clear and overflow-clear pulses return their flags to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master_i | input | 1 | Selected channel operates as master |
| smc_i | input | 1 | Start-on-write control |
| wave_i | input | NCH | Per-channel continuous-burst waveform bits |
| chan_i | input | CH_W | Selected channel |
| burst_field_i | input | BLEN_W | Burst length minus one, in bits |
| tx_wr_i | input | 1 | Pulse: a word was written to the transmit queue |
| xch_req_i | input | 1 | Pulse: exchange request |
| done_clr_i | input | 1 | Pulse: clear transfer-complete |
| ovf_clr_i | input | 1 | Pulse: clear overflow |
| tx_valid_i | input | 1 | Transmit queue is not empty |
| tx_data_i | input | WORD_W | Head word of the transmit queue |
| tx_pop_o | output | 1 | Take the head word |
| rx_full_i | input | 1 | Receive queue is full |
| rx_push_o | output | 1 | Push the assembled word |
| rx_data_o | output | WORD_W | Assembled receive word |
| byte_req_o | output | 1 | Byte waiting for the shifter |
| byte_out_o | output | 8 | Byte to shift out |
| byte_done_i | input | 1 | Shifter finished the byte |
| byte_in_i | input | 8 | Byte captured by the shifter |
| xfer_done_o | output | 1 | Transfer-complete flag |
| overflow_o | output | 1 | Receive overflow flag |
| xch_busy_o | output | 1 | Exchange in progress |

## Verification
The assertions check properties that must hold on every cycle. These are the byte handshake holding its value until byte-done, no pop from an empty queue and no push into a full one, overflow rising only on a full queue, exchange-busy falling only after an empty queue was seen, and the bound on the remaining count. Other behaviour can only be shown by the bench's scenarios, which track the remaining count across runs. These include the byte count for each word under many burst lengths, the byte order and receive packing, pausing against continuous draining, the words left in the queue, and which start events are ignored.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_SHIFT,
      ST_STORE,
      ST_DONE
   } eng_state_t;
endpackage

// File: rtl/spi_burst_len.sv
// Remaining-bit counter of the current burst and the byte count for each word.
module spi_burst_len #(
   parameter int BLEN_W = 12,
   parameter int WORD_W = 32,
   localparam int CNT_W = $clog2(WORD_W / 8 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [BLEN_W-1:0] field_i,
   output logic              expired_o,
   output logic [CNT_W-1:0]  nbytes_o
);
   localparam int RW = BLEN_W + 2;

   logic signed [RW-1:0] rem_q;
   logic signed [RW-1:0] eff;
   logic signed [RW-1:0] bits;
   logic signed [RW-1:0] nb_full;

   assign expired_o = (rem_q <= 0);

   always_comb begin
      eff = rem_q;
      if (expired_o) eff = $signed({2'b00, field_i}) + $signed(RW'(1));
      bits    = (eff > WORD_W) ? $signed(RW'(WORD_W)) : eff;
      nb_full = (bits + $signed(RW'(7))) >>> 3;
      nbytes_o = nb_full[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rem_q <= '0;
      else if (load_i)  rem_q <= eff;
      else if (step_i)  rem_q <= rem_q - $signed(RW'(8));
   end

   // R3
   rem_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rem_q > -8);

   // R2
   load_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && step_i));
endmodule

// File: rtl/spi_burst_pack.sv
// Transmit shift register and lane-wise assembly of the receive word.
module spi_burst_pack #(
   parameter int WORD_W = 32,
   localparam int NB = WORD_W / 8,
   localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              step_i,
   input  logic [7:0]        byte_in_i,
   output logic [7:0]        byte_out_o,
   output logic [WORD_W-1:0] rx_word_o
);
   logic [WORD_W-1:0] sh_q;
   logic [IDX_W-1:0]  idx_q;

   assign byte_out_o = sh_q[7:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load_i) begin
         sh_q  <= word_i;
         idx_q <= '0;
      end else if (step_i) begin
         sh_q  <= sh_q >> 8;
         idx_q <= idx_q + IDX_W'(1);
      end
   end

   for (genvar k = 0; k < NB; k++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 rx_word_o[8*k +: 8] <= '0;
         else if (load_i)                            rx_word_o[8*k +: 8] <= '0;
         else if (step_i && idx_q == IDX_W'(k))      rx_word_o[8*k +: 8] <= byte_in_i;
      end
   end

   // R3
   byte_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (byte_out_o == $past(sh_q[15:8])));
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
   import spi_burst_pkg::*;
#(
   parameter int BLEN_W = 12,
   parameter int WORD_W = 32,
   parameter int NCH    = 4,
   localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_master_i,
   input  logic              smc_i,
   input  logic [NCH-1:0]    wave_i,
   input  logic [CH_W-1:0]   chan_i,
   input  logic [BLEN_W-1:0] burst_field_i,
   input  logic              tx_wr_i,
   input  logic              xch_req_i,
   input  logic              done_clr_i,
   input  logic              ovf_clr_i,
   input  logic              tx_valid_i,
   input  logic [WORD_W-1:0] tx_data_i,
   output logic              tx_pop_o,
   input  logic              rx_full_i,
   output logic              rx_push_o,
   output logic [WORD_W-1:0] rx_data_o,
   output logic              byte_req_o,
   output logic [7:0]        byte_out_o,
   input  logic              byte_done_i,
   input  logic [7:0]        byte_in_i,
   output logic              xfer_done_o,
   output logic              overflow_o,
   output logic              xch_busy_o
);
   localparam int CNT_W = $clog2(WORD_W / 8 + 1);

   if (WORD_W % 8 != 0 || WORD_W < 16) begin : g_bad_word
      $error("WORD_W must be a multiple of 8 and at least 16");
   end
   if (BLEN_W < 1) begin : g_bad_len
      $error("BLEN_W must be positive");
   end

   eng_state_t       st_q, st_d;
   logic [CNT_W-1:0] left_q;
   logic [CNT_W-1:0] nbytes;
   logic             expired;
   logic             multi;
   logic             trig_wr, trig_xch;
   logic             load, step;
   logic             set_done, set_ovf, set_xch, clr_xch;

   assign multi    = is_master_i && !smc_i && wave_i[chan_i];
   assign trig_wr  = is_master_i && smc_i && tx_wr_i;
   assign trig_xch = is_master_i && !smc_i && xch_req_i;

   assign load       = (st_q == ST_LOAD) && tx_valid_i;
   assign step       = (st_q == ST_SHIFT) && byte_done_i;
   assign tx_pop_o   = load;
   assign byte_req_o = (st_q == ST_SHIFT);
   assign rx_push_o  = (st_q == ST_STORE) && !rx_full_i;
   assign set_ovf    = (st_q == ST_STORE) && rx_full_i;
   assign set_done   = (st_q == ST_DONE);
   assign clr_xch    = (st_q == ST_DONE) && !tx_valid_i;
   assign set_xch    = ((st_q == ST_IDLE) && trig_xch) || (load && expired && multi);

   spi_burst_len #(.BLEN_W(BLEN_W), .WORD_W(WORD_W)) i_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .step_i    (step),
      .field_i   (burst_field_i),
      .expired_o (expired),
      .nbytes_o  (nbytes)
   );

   spi_burst_pack #(.WORD_W(WORD_W)) i_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .word_i     (tx_data_i),
      .step_i     (step),
      .byte_in_i  (byte_in_i),
      .byte_out_o (byte_out_o),
      .rx_word_o  (rx_data_o)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (trig_wr || trig_xch) st_d = ST_LOAD;
         ST_LOAD:  st_d = tx_valid_i ? ST_SHIFT : ST_DONE;
         ST_SHIFT: if (byte_done_i && left_q == CNT_W'(1)) st_d = ST_STORE;
         ST_STORE: st_d = (expired && !multi) ? ST_DONE : ST_LOAD;
         ST_DONE:  st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         left_q      <= '0;
         xfer_done_o <= 1'b0;
         overflow_o  <= 1'b0;
         xch_busy_o  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (load)      left_q <= nbytes;
         else if (step) left_q <= left_q - CNT_W'(1);
         if (set_done)        xfer_done_o <= 1'b1;
         else if (done_clr_i) xfer_done_o <= 1'b0;
         if (set_ovf)         overflow_o <= 1'b1;
         else if (ovf_clr_i)  overflow_o <= 1'b0;
         if (set_xch)         xch_busy_o <= 1'b1;
         else if (clr_xch)    xch_busy_o <= 1'b0;
      end
   end

   // R4
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_req_o && !byte_done_i) |=> (byte_req_o && $stable(byte_out_o)));

   // R6
   no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push_o |-> !rx_full_i);

   // R6
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow_o) |-> $past(rx_full_i));

   // R10
   no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop_o |-> tx_valid_i);

   // R9
   xch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xch_busy_o) |-> !$past(tx_valid_i));

   // R5
   one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_pop_o, rx_push_o, byte_req_o}));
endmodule

// File: tb/test_spi_burst_engine.sv
module test_spi_burst_engine;
   localparam int CLK_PERIOD = 10;
   localparam int BLEN_W = 12;
   localparam int WORD_W = 32;
   localparam int NCH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic is_master = 1'b1, smc = 1'b1;
   logic [NCH-1:0] wave = '0;
   logic [1:0] chan = '0;
   logic [BLEN_W-1:0] field = '0;
   logic tx_wr = 1'b0, xch_req = 1'b0, done_clr = 1'b0, ovf_clr = 1'b0;
   logic tx_valid, tx_pop, rx_full, rx_push, byte_req, byte_done = 1'b0;
   logic [WORD_W-1:0] tx_data, rx_data;
   logic [7:0] byte_out, byte_in = '0;
   logic xfer_done, overflow, xch_busy;

   logic [31:0] tx_mem [0:1023];
   logic [31:0] rx_log [0:1023];
   logic [7:0]  byte_log [0:4095];
   int tx_total = 0, tx_rd = 0, rx_wr = 0, rx_base = 0, rx_cap = 1000, byte_wr = 0;
   int sh_cnt = 0, pop_no_xch = 0;
   logic sh_busy = 1'b0;
   int checks = 0, fails = 0, seed = 0, brem = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign tx_valid = tx_total > tx_rd;
   assign tx_data  = tx_mem[tx_rd[9:0]];
   assign rx_full  = (rx_wr - rx_base) >= rx_cap;

   spi_burst_engine #(.BLEN_W(BLEN_W), .WORD_W(WORD_W), .NCH(NCH)) i_spi_burst_engine (
      .clk(clk), .rst_n(rst_n), .is_master_i(is_master), .smc_i(smc), .wave_i(wave),
      .chan_i(chan), .burst_field_i(field), .tx_wr_i(tx_wr), .xch_req_i(xch_req),
      .done_clr_i(done_clr), .ovf_clr_i(ovf_clr), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
      .tx_pop_o(tx_pop), .rx_full_i(rx_full), .rx_push_o(rx_push), .rx_data_o(rx_data),
      .byte_req_o(byte_req), .byte_out_o(byte_out), .byte_done_i(byte_done), .byte_in_i(byte_in),
      .xfer_done_o(xfer_done), .overflow_o(overflow), .xch_busy_o(xch_busy)
   );

   // queue and shifter models
   always @(posedge clk) begin
      if (tx_pop) begin
         tx_rd <= tx_rd + 1;
         if (!xch_busy) pop_no_xch <= pop_no_xch + 1;
      end
      if (rx_push && !rx_full) begin
         rx_log[rx_wr[9:0]] <= rx_data;
         rx_wr <= rx_wr + 1;
      end
      if (byte_done) byte_done <= 1'b0;
      else if (sh_busy) begin
         if (sh_cnt == 0) begin byte_done <= 1'b1; sh_busy <= 1'b0; end
         else sh_cnt <= sh_cnt - 1;
      end else if (byte_req) begin
         byte_log[byte_wr[11:0]] <= byte_out;
         byte_wr <= byte_wr + 1;
         byte_in <= byte_out ^ 8'h5A;
         sh_busy <= 1'b1;
         sh_cnt  <= byte_wr % 3;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_case(input int fv, input int nwords, input bit s_smc, input bit via_xch,
                           input bit master, input logic [3:0] wv, input int ch, input int cap);
      bit run, mlt, exp_xch;
      int r0, b0, p, nbt, nw, bad_b, bad_r, r, bits, nb;
      logic [31:0] w, erx;
      @(negedge clk);
      field = BLEN_W'(fv); smc = s_smc; is_master = master; wave = wv; chan = 2'(ch);
      done_clr = 1'b1; ovf_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0; ovf_clr = 1'b0;
      // R11
      check(!xfer_done && !overflow, "R11", "flags after clear", {xfer_done, overflow}, 0);
      rx_base = rx_wr; rx_cap = cap; pop_no_xch = 0;
      for (int i = 0; i < nwords; i++) begin
         tx_mem[tx_total[9:0]] = {8'(seed*4+3), 8'(seed*4+2), 8'(seed*4+1), 8'(seed*4)} ^ 32'h9E3779B9;
         tx_total++; seed++;
      end
      r0 = tx_rd; b0 = byte_wr;
      exp_xch = xch_busy;
      if (via_xch) xch_req = 1'b1; else tx_wr = 1'b1;
      @(negedge clk);
      xch_req = 1'b0; tx_wr = 1'b0;
      run = master && (via_xch ? !s_smc : s_smc);
      mlt = master && !s_smc && wv[ch];
      if (!run) begin
         repeat (40) @(negedge clk);
         // R10
         check(byte_wr == b0, "R10", "bytes on ignored start", byte_wr - b0, 0);
         check(tx_rd == r0 && !xfer_done, "R10", "queue/done on ignored start", tx_rd - r0, 0);
         return;
      end
      for (int t = 0; t < 6000 && !xfer_done; t++) @(negedge clk);
      @(negedge clk);
      p = r0; nbt = 0; nw = 0; bad_b = 0; bad_r = 0; r = brem;
      while (p < tx_total) begin
         if (r <= 0) r = fv + 1;
         bits = (r > 32) ? 32 : r;
         nb = (bits + 7) / 8;
         w = tx_mem[p[9:0]]; erx = '0;
         for (int k = 0; k < nb; k++) begin
            if (byte_log[(b0 + nbt) % 4096] !== w[8*k +: 8]) bad_b++;
            erx[8*k +: 8] = w[8*k +: 8] ^ 8'h5A;
            nbt++;
         end
         r -= 8 * nb;
         if (nw < cap && rx_log[(rx_base + nw) % 1024] !== erx) bad_r++;
         nw++; p++;
         if (r <= 0 && !mlt) break;
      end
      brem = r;
      if (via_xch) exp_xch = 1'b1;
      if (p == tx_total) exp_xch = 1'b0;
      // R2 R3
      check(byte_wr - b0 == nbt, "R2", "bytes shifted", byte_wr - b0, nbt);
      check(bad_b == 0, "R3", "byte order mismatches", bad_b, 0);
      // R4 R5
      check(bad_r == 0, "R5", "rx word mismatches", bad_r, 0);
      // R6
      check(rx_wr - rx_base == ((nw < cap) ? nw : cap), "R6", "words pushed", rx_wr - rx_base,
            (nw < cap) ? nw : cap);
      check(overflow == (nw > cap), "R6", "overflow flag", overflow, nw > cap);
      // R7 R8
      check(tx_rd == p, mlt ? "R8" : "R7", "words consumed", tx_rd - r0, p - r0);
      check(xfer_done, "R7", "transfer complete", xfer_done, 1);
      // R9
      check(xch_busy == exp_xch, "R9", "exchange busy", xch_busy, exp_xch);
      if (mlt) check(pop_no_xch == 0, "R8", "pops without exchange busy", pop_no_xch, 0);
   endtask

   int sweep_f [13] = '{0, 7, 8, 15, 16, 23, 31, 32, 39, 63, 64, 95, 100};
   int multi_f [5]  = '{7, 31, 39, 70, 200};

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check(!xfer_done && !overflow && !xch_busy, "R1", "flags at reset",
            {xfer_done, overflow, xch_busy}, 0);
      check(!tx_pop && !rx_push && !byte_req, "R1", "requests at reset",
            {tx_pop, rx_push, byte_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!tx_pop && !byte_req, "R1", "idle after reset", {tx_pop, byte_req}, 0);
      // R2 R3 R7: start-on-write, pausing bursts
      foreach (sweep_f[i]) run_case(sweep_f[i], 3, 1'b1, 1'b0, 1'b1, 4'b0000, 0, 1000);
      // R7 R9: exchange start, waveform bit of other channel -> pauses, busy held
      run_case(39, 2, 1'b0, 1'b1, 1'b1, 4'b0100, 1, 1000);
      run_case(15, 1, 1'b0, 1'b1, 1'b1, 4'b0100, 3, 1000);
      // R10: ignored starts
      run_case(31, 2, 1'b0, 1'b0, 1'b1, 4'b1111, 0, 1000);
      run_case(31, 1, 1'b0, 1'b1, 1'b0, 4'b1111, 0, 1000);
      run_case(31, 1, 1'b1, 1'b1, 1'b1, 4'b1111, 0, 1000);
      // R8: continuous mode drains across bursts
      foreach (multi_f[i]) run_case(multi_f[i], 5, 1'b0, 1'b1, 1'b1, 4'b0100, 2, 1000);
      // R6: overflow
      run_case(255, 5, 1'b0, 1'b1, 1'b1, 4'b0001, 0, 2);
      // R9: empty queue start
      run_case(7, 0, 1'b0, 1'b1, 1'b1, 4'b0001, 0, 1000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule